// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a DMA transfer engine with 32 channels. Every cycle it looks at each channel's peripheral request lines and pending software request, filters them through that channel's enable, peripheral-mask and burst-only controls, and selects one winner. The winner is reported to the engine as a one-cycle grant that carries the channel number and whether the transfer is a burst or a single item. The engine tells the arbiter when it is busy, and it reports completed transfers so that software requests can retire.

Each channel has a priority bit. A requesting channel at the high level beats every channel at the default level. Within a level, the lowest-numbered channel wins. The block also exports a per-channel wait vector. It shows which burst-only channels are being held off by a peripheral that raises only its single-request line.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel whose `chan_en_i` bit is 0 is never granted, whatever its request inputs or pending software request.
- R2: When a channel's `req_mask_i` bit is 1, its `per_single_i` and `per_burst_i` lines produce no grant. A pending software request on that channel is still granted.
- R3: When a channel's `burst_only_i` bit is 1, its `per_single_i` line alone produces no grant. Its `per_burst_i` line still does.
- R4: If any requesting channel has its `hi_prio_i` bit at 1, the granted channel is one of those high-level channels.
- R5: Within the chosen priority level, the lowest-numbered requesting channel is granted.
- R6: A 1 on `sw_req_set_i[n]` at a clock edge makes channel n's software request pending from the next cycle. It stays pending, and is granted again whenever arbitration allows, until an edge where `xfer_done_i` is 1 with `xfer_done_ch_i` equal to n. From that edge on, the pending request is cleared.
- R7: A grant is issued at a clock edge only if `engine_busy_i` was 0 and `grant_valid_o` was 0 in the cycle before that edge. Each grant is therefore a single-cycle pulse, with at least one idle cycle between grants. The grant reflects the inputs sampled at that edge.
- R8: `grant_burst_o` is 1 when the granted channel has a pending software request or its `per_burst_i` line is 1. Otherwise it is 0. `grant_ch_o` and `grant_burst_o` read 0 while `grant_valid_o` is 0.
- R9: One edge after the inputs are sampled, `wait_req_o[n]` is 1 exactly when channel n is enabled, not masked, burst-only, and has `per_single_i` at 1 and `per_burst_i` at 0.
- R10: During and right after reset, all outputs are 0 and no software request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_single_i | input | 32 | Peripheral single-item request, one bit per channel |
| per_burst_i | input | 32 | Peripheral burst request, one bit per channel |
| sw_req_set_i | input | 32 | Pulse that posts a software request per channel |
| chan_en_i | input | 32 | Channel enable |
| req_mask_i | input | 32 | 1 blocks the channel's peripheral requests |
| burst_only_i | input | 32 | 1 makes the channel ignore its single-request line |
| hi_prio_i | input | 32 | 1 puts the channel at the high priority level |
| engine_busy_i | input | 1 | Engine is occupied; no new grant |
| xfer_done_i | input | 1 | Engine finished a transfer this cycle |
| xfer_done_ch_i | input | 5 | Channel whose transfer finished |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_ch_o | output | 5 | Granted channel number |
| grant_burst_o | output | 1 | 1 burst, 0 single item |
| wait_req_o | output | 32 | Per-channel wait-on-request status |

## Verification
Peripheral requests, the enable, mask, burst-only and priority controls, and the busy flag all show up in `grant_valid_o`, `grant_ch_o` and `grant_burst_o` one rising edge after they are driven. `wait_req_o` also follows its inputs with one edge of delay. A software request takes two edges: one to become pending and one to be granted. A completion pulse stops regrants from the edge after it.

The bench drives inputs on the falling edge. It predicts the next grant from a cycle model of pending software requests and the previous grant, then samples the outputs on the following falling edge. That way each expected value is compared in exactly the cycle it is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      XFER_SINGLE = 1'b0,
      XFER_BURST  = 1'b1
   } xfer_kind_e;

endpackage

// File: rtl/dma_arb_swreq.sv
module dma_arb_swreq #(
   parameter  int NUM_CH = 32,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              done_i,
   input  logic [CH_W-1:0]   done_ch_i,
   output logic [NUM_CH-1:0] pend_o
);

   logic [NUM_CH-1:0] retire;

   // Decode of the completion pulse into a per-channel clear mask.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_retire
      assign retire[c] = done_i && (done_ch_i == CH_W'(c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
      end else begin
         pend_o <= (pend_o & ~retire) | set_i;
      end
   end

   // R6: a completion on a channel with no new post leaves it idle.
   a_r6_retire_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !set_i[done_ch_i]) |=> !pend_o[$past(done_ch_i)]);

endmodule

// File: rtl/dma_arb_qualify.sv
module dma_arb_qualify #(
   parameter int NUM_CH = 32
) (
   input  logic [NUM_CH-1:0] per_single_i,
   input  logic [NUM_CH-1:0] per_burst_i,
   input  logic [NUM_CH-1:0] sw_pend_i,
   input  logic [NUM_CH-1:0] chan_en_i,
   input  logic [NUM_CH-1:0] req_mask_i,
   input  logic [NUM_CH-1:0] burst_only_i,
   input  logic [NUM_CH-1:0] hi_prio_i,
   output logic [NUM_CH-1:0] req_hi_o,
   output logic [NUM_CH-1:0] req_lo_o,
   output logic [NUM_CH-1:0] burst_o,
   output logic [NUM_CH-1:0] wait_o
);

   import dma_arb_pkg::*;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic       single_ok;
      logic       periph_req;
      logic       any_req;
      xfer_kind_e kind;

      assign single_ok  = per_single_i[c] && !burst_only_i[c];
      assign periph_req = (per_burst_i[c] || single_ok) && !req_mask_i[c];
      assign any_req    = chan_en_i[c] && (sw_pend_i[c] || periph_req);
      assign kind       = (sw_pend_i[c] || per_burst_i[c]) ? XFER_BURST : XFER_SINGLE;

      assign req_hi_o[c] = any_req && hi_prio_i[c];
      assign req_lo_o[c] = any_req && !hi_prio_i[c];
      assign burst_o[c]  = (kind == XFER_BURST);
      assign wait_o[c]   = chan_en_i[c] && !req_mask_i[c] && burst_only_i[c]
                           && per_single_i[c] && !per_burst_i[c];
   end

   // R1: a disabled channel never raises a request at either level.
   a_r1_disabled_quiet : assert final (((req_hi_o | req_lo_o) & ~chan_en_i) == '0);

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter  int NUM_CH          = 32,
   parameter  bit LOW_INDEX_FIRST = 1'b1,
   localparam int CH_W            = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] vec_i,
   output logic              any_o,
   output logic [CH_W-1:0]   idx_o
);

   assign any_o = |vec_i;

   if (LOW_INDEX_FIRST) begin : g_low
      always_comb begin
         idx_o = '0;
         for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (vec_i[c]) idx_o = CH_W'(c);
         end
      end
   end else begin : g_high
      always_comb begin
         idx_o = '0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (vec_i[c]) idx_o = CH_W'(c);
         end
      end
   end

   // R5: the selected index is itself a requesting channel.
   a_r5_pick_is_set : assert final (!any_o || vec_i[idx_o]);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
   parameter  int NUM_CH          = 32,
   parameter  bit LOW_INDEX_FIRST = 1'b1,
   localparam int CH_W            = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] per_single_i,
   input  logic [NUM_CH-1:0] per_burst_i,
   input  logic [NUM_CH-1:0] sw_req_set_i,
   input  logic [NUM_CH-1:0] chan_en_i,
   input  logic [NUM_CH-1:0] req_mask_i,
   input  logic [NUM_CH-1:0] burst_only_i,
   input  logic [NUM_CH-1:0] hi_prio_i,
   input  logic              engine_busy_i,
   input  logic              xfer_done_i,
   input  logic [CH_W-1:0]   xfer_done_ch_i,
   output logic              grant_valid_o,
   output logic [CH_W-1:0]   grant_ch_o,
   output logic              grant_burst_o,
   output logic [NUM_CH-1:0] wait_req_o
);

   if (NUM_CH < 2 || NUM_CH > 1024) begin : g_bad_cfg
      $error("dma_req_arbiter: NUM_CH must lie in 2..1024");
   end

   logic [NUM_CH-1:0] sw_pend;
   logic [NUM_CH-1:0] req_hi;
   logic [NUM_CH-1:0] req_lo;
   logic [NUM_CH-1:0] burst_vec;
   logic [NUM_CH-1:0] wait_now;
   logic              hi_any;
   logic              lo_any;
   logic [CH_W-1:0]   hi_idx;
   logic [CH_W-1:0]   lo_idx;
   logic              take;
   logic [CH_W-1:0]   win_ch;

   dma_arb_swreq #(.NUM_CH(NUM_CH)) u_swreq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (sw_req_set_i),
      .done_i    (xfer_done_i),
      .done_ch_i (xfer_done_ch_i),
      .pend_o    (sw_pend)
   );

   dma_arb_qualify #(.NUM_CH(NUM_CH)) u_qual (
      .per_single_i (per_single_i),
      .per_burst_i  (per_burst_i),
      .sw_pend_i    (sw_pend),
      .chan_en_i    (chan_en_i),
      .req_mask_i   (req_mask_i),
      .burst_only_i (burst_only_i),
      .hi_prio_i    (hi_prio_i),
      .req_hi_o     (req_hi),
      .req_lo_o     (req_lo),
      .burst_o      (burst_vec),
      .wait_o       (wait_now)
   );

   dma_arb_pick #(.NUM_CH(NUM_CH), .LOW_INDEX_FIRST(LOW_INDEX_FIRST)) u_pick_hi (
      .vec_i (req_hi),
      .any_o (hi_any),
      .idx_o (hi_idx)
   );

   dma_arb_pick #(.NUM_CH(NUM_CH), .LOW_INDEX_FIRST(LOW_INDEX_FIRST)) u_pick_lo (
      .vec_i (req_lo),
      .any_o (lo_any),
      .idx_o (lo_idx)
   );

   assign take   = !engine_busy_i && !grant_valid_o && (hi_any || lo_any);
   assign win_ch = hi_any ? hi_idx : lo_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid_o <= 1'b0;
         grant_ch_o    <= '0;
         grant_burst_o <= 1'b0;
         wait_req_o    <= '0;
      end else begin
         grant_valid_o <= take;
         grant_ch_o    <= take ? win_ch : '0;
         grant_burst_o <= take && burst_vec[win_ch];
         wait_req_o    <= wait_now;
      end
   end

   // Sampled copies of the qualified request view, kept for the checks below.
   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] hi_q;
   logic [NUM_CH-1:0] req_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         hi_q  <= '0;
         req_q <= '0;
      end else begin
         en_q  <= chan_en_i;
         hi_q  <= req_hi;
         req_q <= req_hi | req_lo;
      end
   end

   a_r7_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |=> !grant_valid_o);

   a_r7_busy_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      engine_busy_i |=> !grant_valid_o);

   a_r1_grant_enabled : assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> en_q[grant_ch_o]);

   a_r4_high_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid_o && (hi_q != '0)) |-> hi_q[grant_ch_o]);

   a_r5_grant_requested : assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> req_q[grant_ch_o]);

   a_r8_idle_fields_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid_o |-> (grant_ch_o == '0 && !grant_burst_o));

endmodule

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

   localparam int N  = 32;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  ps = '0, pb = '0, sws = '0, en = '0, msk = '0, bo = '0, hi = '0;
   logic          busy = 1'b0, done = 1'b0;
   logic [CW-1:0] dch = '0;
   logic          gv, gb;
   logic [CW-1:0] gch;
   logic [N-1:0]  wr;

   int checks = 0;
   int errors = 0;

   logic [N-1:0]  pend_m = '0;
   logic          gv_prev = 1'b0;

   always #5 clk = ~clk;

   dma_req_arbiter dut_i (
      .clk (clk), .rst_n (rst_n),
      .per_single_i (ps), .per_burst_i (pb), .sw_req_set_i (sws),
      .chan_en_i (en), .req_mask_i (msk), .burst_only_i (bo), .hi_prio_i (hi),
      .engine_busy_i (busy), .xfer_done_i (done), .xfer_done_ch_i (dch),
      .grant_valid_o (gv), .grant_ch_o (gch), .grant_burst_o (gb), .wait_req_o (wr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      ps = '0; pb = '0; sws = '0; en = '0; msk = '0; bo = '0; hi = '0;
      busy = 1'b0; done = 1'b0; dch = '0;
   endtask

   // One clock: predict from the requirements, clock, then compare.
   task automatic cycle();
      logic [N-1:0]  rq, rqh, pool, dmask;
      logic          egv, eb;
      logic [CW-1:0] ech;
      logic [N-1:0]  ew;
      rq    = en & (pend_m | ((pb | (ps & ~bo)) & ~msk));
      rqh   = rq & hi;
      pool  = (rqh != '0) ? rqh : rq;
      egv   = !busy && !gv_prev && (rq != '0);
      ech   = '0;
      for (int c = N - 1; c >= 0; c--) if (pool[c]) ech = CW'(c);
      eb    = egv && (pend_m[ech] || pb[ech]);
      if (!egv) ech = '0;
      ew    = en & ~msk & bo & ps & ~pb;
      dmask = done ? (N'(1) << dch) : '0;
      @(posedge clk);
      @(negedge clk);
      chk(gv == egv, "R7", "grant_valid", 32'(gv), 32'(egv));
      chk(gch == ech, (rqh != '0) ? "R4" : "R5", "grant_ch", 32'(gch), 32'(ech));
      chk(gb == eb, "R8", "grant_burst", 32'(gb), 32'(eb));
      chk(wr == ew, "R9", "wait_req", wr, ew);
      pend_m  = (pend_m & ~dmask) | sws;
      gv_prev = egv;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(gv == 1'b0 && gch == '0 && gb == 1'b0 && wr == '0, "R10", "reset outputs",
          {gv, gb, 25'd0, gch}, 32'd0);
      rst_n = 1'b1;
      cycle();
      chk(gv == 1'b0, "R10", "idle after reset", 32'(gv), 32'd0);

      // R1: disabled channel with a burst request
      pb[4] = 1'b1; cycle();
      chk(gv == 1'b0, "R1", "disabled channel granted", 32'(gv), 32'd0);
      idle(); cycle();

      // R2: masked peripheral ignored, software still honoured
      en[6] = 1'b1; msk[6] = 1'b1; pb[6] = 1'b1; cycle();
      chk(gv == 1'b0, "R2", "masked peripheral granted", 32'(gv), 32'd0);
      sws[6] = 1'b1; cycle();
      sws[6] = 1'b0; cycle();
      chk(gv == 1'b1 && gch == 5'd6 && gb == 1'b1, "R2", "software grant ch6",
          {gv, gb, 25'd0, gch}, {2'b11, 25'd0, 5'd6});
      cycle();
      chk(gv == 1'b0, "R7", "gap after grant", 32'(gv), 32'd0);
      cycle();
      chk(gv == 1'b1 && gch == 5'd6, "R6", "pending regranted", 32'(gch), 32'd6);
      busy = 1'b1; done = 1'b1; dch = 5'd6; cycle();
      busy = 1'b0; done = 1'b0; cycle();
      chk(gv == 1'b0, "R6", "retired request granted", 32'(gv), 32'd0);
      idle(); cycle();

      // R3: burst-only channel ignores single, waits, then takes burst
      en[9] = 1'b1; bo[9] = 1'b1; ps[9] = 1'b1; cycle();
      chk(gv == 1'b0, "R3", "single on burst-only granted", 32'(gv), 32'd0);
      chk(wr[9] == 1'b1, "R9", "wait bit ch9", 32'(wr[9]), 32'd1);
      pb[9] = 1'b1; cycle();
      chk(gv == 1'b1 && gch == 5'd9 && gb == 1'b1, "R3", "burst grant ch9",
          {gv, gb, 25'd0, gch}, {2'b11, 25'd0, 5'd9});
      idle(); cycle();

      // R4 and R8: high-level single beats lower-numbered default burst
      en[2] = 1'b1; pb[2] = 1'b1; en[20] = 1'b1; hi[20] = 1'b1; ps[20] = 1'b1; cycle();
      chk(gv == 1'b1 && gch == 5'd20, "R4", "high level wins", 32'(gch), 32'd20);
      chk(gb == 1'b0, "R8", "single grant flag", 32'(gb), 32'd0);
      idle(); cycle();

      // R5: lowest index within a level
      en[7] = 1'b1; en[12] = 1'b1; ps[7] = 1'b1; ps[12] = 1'b1; cycle();
      chk(gch == 5'd7, "R5", "lowest default", 32'(gch), 32'd7);
      cycle(); hi[12] = 1'b1; cycle();
      chk(gch == 5'd12, "R5", "sole high", 32'(gch), 32'd12);
      cycle(); hi[7] = 1'b1; cycle();
      chk(gch == 5'd7, "R5", "lowest high", 32'(gch), 32'd7);

      // R7: busy engine gets no grant
      cycle(); busy = 1'b1; cycle();
      chk(gv == 1'b0, "R7", "grant while busy", 32'(gv), 32'd0);
      idle(); cycle();

      // Random mix
      for (int k = 0; k < 4000; k++) begin
         en   = $urandom | $urandom;
         msk  = $urandom & $urandom & $urandom;
         bo   = $urandom & $urandom & $urandom;
         hi   = $urandom & $urandom & $urandom;
         ps   = $urandom & $urandom & $urandom;
         pb   = $urandom & $urandom & $urandom & $urandom;
         sws  = ($urandom % 8 == 0) ? (N'(1) << ($urandom % N)) : '0;
         busy = ($urandom % 3 == 0);
         done = ($urandom % 3 == 0);
         dch  = CW'($urandom);
         cycle();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule